// File: doc/BRIEF.md
# Addressed Serial DAC Register Bank

This block is the digital front end of an eight-channel digital-to-analog converter. A three-wire serial port (data in, shift clock, load strobe) fills a 12-bit frame register. Each frame holds a 4-bit channel number and an 8-bit converter code. While the load strobe is high, the code is written into the holding latch of the one channel the number selects. All eight latched codes are presented side by side on a parallel output bus, and each 8-bit slice stands for the code that drives one converter.

The port pins are sampled by the block's system clock, and the block finds the shift-clock edges itself. A serial output repeats the bit that leaves the last stage of the frame register, so several of these blocks can share one data line in a daisy chain. Channel numbers that name no channel are ignored, so a frame meant for another device in the chain can pass through without disturbing this one.

Top module: `serial_dac_bank`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the frame register, `sdo` and all eight channel codes are cleared to zero.
- R2: A frame is 12 bits, shifted in as D11 first and D0 last. D7..D0 form the converter code with D0 as the least significant bit, so an all-ones code (0xFF) reaches the latch as full scale and all-zeros as the lowest level.
- R3: The select value is built from D8 (most significant) down to D11 (least significant). A value n from 1 to 8 addresses channel n, whose code appears on `ch_codes[(n-1)*8 +: 8]`.
- R4: A load with select value 0 or 9 to 15 leaves every channel code unchanged.
- R5: A load changes only the addressed channel. The other seven codes keep their values.
- R6: Shifting bits in while `load` is low changes no channel code.
- R7: `sdi` is sampled at each rising edge of `sclk`. At each falling edge of `sclk`, `sdo` takes the bit held in the last frame-register stage, which is the bit shifted in twelve rising edges earlier. After reset that bit is 0.
- R8: The load is level-sensitive. The addressed latch is written on every `clk` edge at which `load` is high, and holding `load` high over several cycles leaves the same code in the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous reset, active low |
| sclk | input | 1 | Serial shift clock, already synchronised to `clk` |
| sdi | input | 1 | Serial data input |
| load | input | 1 | Level-sensitive load strobe |
| sdo | output | 1 | Cascade output for a downstream device |
| ch_codes | output | 64 | Latched codes, channel n at bits [(n-1)*8 +: 8] |

## Verification
The bench builds the block with its default parameters: eight channels, an 8-bit code and a 4-bit select field. With those values every one of the sixteen select values can be sent, both the invalid codes and the edges of the valid range (1 and 8), and full-scale and zero codes can be loaded. The cascade output is followed across two back-to-back frames, which checks the twelve-bit delay from `sdi` to `sdo`.

// File: rtl/dacb_pkg.sv
// Package: dacb_pkg
// Holds the shared sizes and the select-field decoding for the serial DAC register bank.
// Assumes the frame is the code followed by the select field, with the select bits in reversed weight order.
package dacb_pkg;
    localparam int NUM_CH  = 8;
    localparam int CODE_W  = 8;
    localparam int SEL_W   = 4;
    localparam int FRAME_W = CODE_W + SEL_W;

    // Turns the raw select bits (the oldest bit at the top) into a number, with the oldest bit as the least significant.
    function automatic logic [SEL_W-1:0] sel_value(input logic [SEL_W-1:0] raw);
        logic [SEL_W-1:0] v;
        for (int j = 0; j < SEL_W; j++) begin
            v[j] = raw[SEL_W-1-j];
        end
        return v;
    endfunction
endpackage

// File: rtl/serial_shifter.sv
// Module: serial_shifter
// Finds the edges of the shift clock, shifts serial data in on its rising edge and updates the
// cascade output on its falling edge. Assumes sclk and sdi are already synchronous to clk.
module serial_shifter #(
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               sdi,
    output logic [FRAME_W-1:0] frame,
    output logic               sdo
);
    logic sclk_q;
    logic sclk_rise;
    logic sclk_fall;

    // Finds the shift-clock edges from the current and the previous sample.
    always_comb begin
        sclk_rise = sclk & ~sclk_q;
        sclk_fall = ~sclk & sclk_q;
    end

    // Stores the previous shift-clock sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    // Shifts the frame register by one place at each rising shift-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         frame <= '0;
        else if (sclk_rise) frame <= {frame[FRAME_W-2:0], sdi};
    end

    // Presents the last stage on the cascade output at each falling shift-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         sdo <= 1'b0;
        else if (sclk_fall) sdo <= frame[FRAME_W-1];
    end

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> frame[0] == $past(sdi));

    assert_cascade_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_fall |=> sdo == $past(frame[FRAME_W-1]));

    assert_sdo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdo));
endmodule

// File: rtl/chan_decoder.sv
// Module: chan_decoder
// Turns the select field and the load strobe into one write enable per channel.
// Assumes select value n (1..NUM_CH) addresses channel n. Every other value raises no enable.
module chan_decoder
    import dacb_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int S_W  = SEL_W
) (
    input  logic [S_W-1:0]  sel_raw,
    input  logic            load,
    output logic [N_CH-1:0] we
);
    logic [S_W-1:0] sel;

    // Puts the select bits into numeric order.
    always_comb begin
        for (int j = 0; j < S_W; j++) sel[j] = sel_raw[S_W-1-j];
    end

    // Raises the enable of the addressed channel while the strobe is high.
    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            we[i] = load && (sel == S_W'(i + 1));
        end
    end

    always_comb begin
        assert_single_enable_R5: assert ($onehot0(we));
    end
endmodule

// File: rtl/code_latch.sv
// Module: code_latch
// Holding register for one channel's code. It takes the new code on every clock edge at which
// its enable is high and holds it otherwise.
module code_latch #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] q
);
    // Loads the code when enabled and clears it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= din;
    end

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/serial_dac_bank.sv
// Module: serial_dac_bank
// Top level of the addressed serial DAC register bank: a serial frame register, the channel
// decoder and one holding latch per channel, with the latched codes side by side on ch_codes.
// Assumes all inputs are synchronous to clk.
module serial_dac_bank
    import dacb_pkg::*;
#(
    parameter int CH     = NUM_CH,
    parameter int CW     = CODE_W,
    parameter int SW     = SEL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk,
    input  logic           sdi,
    input  logic           load,
    output logic           sdo,
    output logic [CH*CW-1:0] ch_codes
);
    localparam int FW = CW + SW;

    logic [FW-1:0] frame;
    logic [CH-1:0] we;
    logic [SW-1:0] sel_num;

    serial_shifter #(.FRAME_W(FW)) i_shifter (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .sdi   (sdi),
        .frame (frame),
        .sdo   (sdo)
    );

    chan_decoder #(.N_CH(CH), .S_W(SW)) i_decoder (
        .sel_raw (frame[FW-1:CW]),
        .load    (load),
        .we      (we)
    );

    // Builds one holding latch for each channel.
    generate
        for (genvar g = 0; g < CH; g++) begin : g_ch
            code_latch #(.CODE_W(CW)) i_latch (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (we[g]),
                .din   (frame[CW-1:0]),
                .q     (ch_codes[g*CW +: CW])
            );

            assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
                we[g] |=> ch_codes[g*CW +: CW] == $past(frame[CW-1:0]));
        end
    endgenerate

    // Numeric select value, used only by the checks below.
    always_comb sel_num = sel_value(frame[FW-1:CW]);

    assert_unused_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (sel_num == '0 || int'(sel_num) > CH)) |=> $stable(ch_codes));

    assert_no_load_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ch_codes));
endmodule

// File: tb/test_serial_dac_bank.sv
module test_serial_dac_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        load = 1'b0;
    logic        sdo;
    logic [63:0] ch_codes;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0]  model [8];
    logic [11:0] mshift = '0;

    // Each entry: {select value, code}.
    localparam logic [11:0] VEC [12] = '{
        {4'd1, 8'h5A}, {4'd8, 8'hC3}, {4'd0, 8'h77}, {4'd4, 8'hFF},
        {4'd9, 8'h11}, {4'd2, 8'h00}, {4'd15, 8'hEE}, {4'd3, 8'h81},
        {4'd5, 8'h01}, {4'd6, 8'h80}, {4'd7, 8'h3C}, {4'd8, 8'h00}
    };

    always #2ns clk = ~clk;

    serial_dac_bank i_serial_dac_bank (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi),
        .load(load), .sdo(sdo), .ch_codes(ch_codes)
    );

    function automatic logic [63:0] model_bus();
        logic [63:0] b;
        for (int i = 0; i < 8; i++) b[i*8 +: 8] = model[i];
        return b;
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: ch_codes actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: sdo actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full shift-clock period; the bench model of the frame register follows it.
    task automatic shift_bit(input logic b);
        sdi = b;
        sclk = 1'b1;
        cycles(2);
        sclk = 1'b0;
        cycles(2);
        mshift = {mshift[10:0], b};
    endtask

    // Sends D11 first: D11..D8 are sel[0]..sel[3], then D7..D0 are code[7]..code[0].
    task automatic send_frame(input logic [3:0] sel, input logic [7:0] code);
        logic [11:0] w;
        w = {sel[0], sel[1], sel[2], sel[3], code};
        for (int i = 11; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic pulse_load(input int len);
        load = 1'b1;
        cycles(len);
        load = 1'b0;
        cycles(1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
        for (int i = 0; i < 8; i++) model[i] = '0;
        mshift = '0;
    endtask

    initial begin
        #(200000 * 4ns);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: state after reset
        check64("R1 reset codes", ch_codes, 64'h0);
        check1("R1 reset sdo", sdo, 1'b0);

        // Table walk: each frame is shifted, checked for no effect, then loaded.
        for (int k = 0; k < 12; k++) begin
            logic [3:0] s;
            logic [7:0] c;
            s = VEC[k][11:8];
            c = VEC[k][7:0];
            send_frame(s, c);
            check64("R6 shift without load", ch_codes, model_bus());
            pulse_load(2);
            if (s >= 4'd1 && s <= 4'd8) begin
                model[s-1] = c;
                check64("R2/R3/R5 addressed load", ch_codes, model_bus());
            end else begin
                check64("R4 unused select", ch_codes, model_bus());
            end
        end

        // R8: a long load leaves the same code in the latch
        send_frame(4'd6, 8'hA5);
        model[5] = 8'hA5;
        pulse_load(7);
        check64("R8 long level load", ch_codes, model_bus());

        // R2: full scale and zero at the first and the last channel
        send_frame(4'd1, 8'hFF);
        pulse_load(1);
        model[0] = 8'hFF;
        check64("R2 full scale ch1", ch_codes, model_bus());
        send_frame(4'd8, 8'h00);
        pulse_load(1);
        model[7] = 8'h00;
        check64("R2 zero ch8", ch_codes, model_bus());

        // R1: reset clears loaded data
        do_reset();
        check64("R1 mid-run reset", ch_codes, 64'h0);
        check1("R1 mid-run reset sdo", sdo, 1'b0);

        // R7: cascade output across two frames, compared after every bit
        for (int f = 0; f < 2; f++) begin
            logic [11:0] w;
            w = (f == 0) ? 12'b1011_0011_1001 : 12'b0110_1100_0101;
            for (int i = 11; i >= 0; i--) begin
                shift_bit(w[i]);
                check1("R7 cascade", sdo, mshift[11]);
            end
        end
        check64("R6 cascade leaves codes", ch_codes, 64'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule